// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Unit

This block holds the program counter of a single-cycle processor and presents, in the same cycle, the instruction word stored at that address. Each rising clock edge loads a new program counter, chosen from three candidates. The default candidate is the sequential next word. The second is a conditional branch target, built from the 16-bit offset in the low bits of the current instruction. The third is an absolute jump target, taken from the 26-bit field of the current instruction. The surrounding datapath supplies the branch request, the ALU zero flag and the jump request. Decoding and execution happen outside this block.

The instruction store is a read-only word array inside the block. Its contents are computed from each word's index and a seed parameter, so every word is known without a load path. The array is indexed by program counter bits [IMEM_IDX_W+1:2]. Addresses beyond the array alias back onto it.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) makes `pc` equal 0 after that edge.
- R2: `instr` is combinational and equals `(idx * 32'h9E3779B1) ^ ROM_SEED`, computed modulo 2^32. Here `idx` is `pc[IMEM_IDX_W+1:2]`, zero-extended, and the default `ROM_SEED` is 32'h1234_5678.
- R3: With `jump` low and `br_sel` low, the next `pc` is `pc + 4`.
- R4: With `jump` low, `br_sel` high and `alu_zero` high, the next `pc` is `pc + 4 + {sign-extended instr[15:0], 2'b00}`. Negative offsets move backwards.
- R5: With `jump` low, `br_sel` high and `alu_zero` low, the next `pc` is `pc + 4`.
- R6: With `jump` high, the next `pc` is `{(pc+4)[31:28], instr[25:0], 2'b00}`.
- R7: A jump takes priority over a branch: when `jump` and a taken branch occur in the same cycle, the jump target of R6 is loaded.
- R8: `pc[1:0]` is always 0. An address beyond the array reads the word whose index is the address modulo the array depth.
- R9: `alu_zero` has no effect on the next `pc` while `br_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU zero flag; qualifies the branch |
| jump | input | 1 | Current instruction is an absolute jump |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word at `pc` |

## Verification
The bound checker verifies on every cycle the next-address rules: the reset value, the sequential step, the taken and not-taken branch, the jump with its priority over the branch, and the alignment of `pc`. Only the bench scenarios can show that each fetched word matches the seeded contents. They also show that addresses wrapping past the array read the aliased word, and that a reset in the middle of a run returns fetch to address 0. The bench compares against a model that walks the address space under random branch, zero and jump patterns.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
    localparam int unsigned PC_W    = 32;
    localparam int unsigned OFF_W   = 16;
    localparam int unsigned TGT_W   = 26;
    localparam int unsigned STEP    = 4;
    localparam int unsigned REGION_W = PC_W - TGT_W - 2;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } pc_src_e;

    typedef struct packed {
        pc_t pc;
    } fetch_state_t;

    function automatic pc_t scaled_offset(input logic [OFF_W-1:0] off);
        return {{(PC_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction
endpackage

// File: rtl/fetch_rom.sv
`timescale 1ns/1ps
module fetch_rom #(
    parameter int unsigned IDX_W = 8,
    parameter logic [31:0] SEED  = 32'h1234_5678,
    parameter logic [31:0] MULT  = 32'h9E37_79B1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    localparam int unsigned PAD_W = 32 - IDX_W;

    logic [31:0] idx_ext;
    logic [31:0] product;

    always_comb begin
        idx_ext = {{PAD_W{1'b0}}, idx};
        product = idx_ext * MULT;
        word    = product ^ SEED;
    end
endmodule

// File: rtl/fetch_src_sel.sv
`timescale 1ns/1ps
module fetch_src_sel
    import fetch_pkg::*;
(
    input  logic    br_sel,
    input  logic    alu_zero,
    input  logic    jump,
    output pc_src_e src
);
    logic br_taken;

    always_comb begin
        br_taken = br_sel & alu_zero;
        if (jump)
            src = SRC_JUMP;
        else if (br_taken)
            src = SRC_BRANCH;
        else
            src = SRC_SEQ;
    end
endmodule

// File: rtl/fetch_npc.sv
`timescale 1ns/1ps
module fetch_npc
    import fetch_pkg::*;
(
    input  pc_t              pc_cur,
    input  logic [TGT_W-1:0] tgt_field,
    input  pc_src_e          src,
    output pc_t              pc_next
);
    pc_t              seq_pc;
    pc_t              br_pc;
    pc_t              jmp_pc;
    logic [OFF_W-1:0] off_field;

    always_comb begin
        off_field = tgt_field[OFF_W-1:0];
        seq_pc    = pc_cur + pc_t'(STEP);
        br_pc     = seq_pc + scaled_offset(off_field);
        jmp_pc    = {seq_pc[PC_W-1 -: REGION_W], tgt_field, 2'b00};
        unique case (src)
            SRC_BRANCH: pc_next = br_pc;
            SRC_JUMP:   pc_next = jmp_pc;
            default:    pc_next = seq_pc;
        endcase
    end
endmodule

// File: rtl/fetch_unit.sv
`timescale 1ns/1ps
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int unsigned IMEM_IDX_W = 8,
    parameter logic [31:0] ROM_SEED   = 32'h1234_5678
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_sel,
    input  logic        alu_zero,
    input  logic        jump,
    output logic [31:0] pc,
    output logic [31:0] instr
);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = IMEM_IDX_W + 1;

    fetch_state_t     state_d;
    fetch_state_t     state_q;
    pc_src_e          src;
    pc_t              pc_next;
    logic [31:0]      word;
    logic [IMEM_IDX_W-1:0] rd_idx;

    assign rd_idx = state_q.pc[IDX_HI:IDX_LO];

    fetch_rom #(
        .IDX_W (IMEM_IDX_W),
        .SEED  (ROM_SEED)
    ) u_rom (
        .idx  (rd_idx),
        .word (word)
    );

    fetch_src_sel u_sel (
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .jump     (jump),
        .src      (src)
    );

    fetch_npc u_npc (
        .pc_cur    (state_q.pc),
        .tgt_field (word[TGT_W-1:0]),
        .src       (src),
        .pc_next   (pc_next)
    );

    always_comb begin
        state_d    = state_q;
        state_d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign pc    = state_q.pc;
    assign instr = word;
endmodule

// File: rtl/fetch_unit_chk.sv
`timescale 1ns/1ps
module fetch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        br_sel,
    input logic        alu_zero,
    input logic        jump,
    input logic [31:0] pc,
    input logic [31:0] instr
);
    logic [31:0] seq;
    logic [31:0] boff;
    assign seq  = pc + 32'd4;
    assign boff = {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == 32'd0);

    // R8
    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R3, R9
    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (!jump && !br_sel) |=> pc == $past(seq));

    // R4
    a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_sel && alu_zero) |=> pc == $past(seq) + $past(boff));

    // R5
    a_r5_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_sel && !alu_zero) |=> pc == $past(seq));

    // R6, R7
    a_r6_jump: assert property (@(posedge clk) disable iff (rst)
        jump |=> pc == {$past(seq[31:28]), $past(instr[25:0]), 2'b00});
endmodule

bind fetch_unit fetch_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .br_sel   (br_sel),
    .alu_zero (alu_zero),
    .jump     (jump),
    .pc       (pc),
    .instr    (instr)
);

// File: tb/test_fetch_unit.sv
`timescale 1ns/1ps
module test_fetch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        alu_zero = 1'b0;
    logic        jump = 1'b0;
    logic [31:0] pc;
    logic [31:0] instr;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] exp_pc = 32'd0;
    bit          done = 1'b0;

    fetch_unit i_fetch_unit (
        .clk(clk), .rst(rst), .br_sel(br_sel), .alu_zero(alu_zero),
        .jump(jump), .pc(pc), .instr(instr)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] rom_word(input logic [31:0] a);
        logic [31:0] idx;
        idx = {24'd0, a[9:2]};
        return (idx * 32'h9E3779B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] w,
                                               input bit b, input bit z, input bit j);
        logic [31:0] s;
        s = p + 32'd4;
        if (j) return {s[31:28], w[25:0], 2'b00};
        if (b && z) return s + {{14{w[15]}}, w[15:0], 2'b00};
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit b, input bit z, input bit j, input string req);
        logic [31:0] w;
        logic [31:0] nxt;
        w = rom_word(exp_pc);
        check(exp_pc[31:10] != 0 ? "R8 wrapped fetch" : "R2 fetch", instr, w);
        nxt = model_next(exp_pc, w, b, z, j);
        br_sel = b; alu_zero = z; jump = j;
        @(negedge clk);
        check(req, pc, nxt);
        exp_pc = nxt;
    endtask

    task automatic do_reset();
        rst = 1'b1; br_sel = 1'b0; alu_zero = 1'b0; jump = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 32'd0);
        check("R2 reset fetch", instr, rom_word(32'd0));
        rst = 1'b0;
        exp_pc = 32'd0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd42));
        @(negedge clk);
        do_reset();
        // directed corner cases
        step(0, 0, 0, "R3 sequential");
        step(0, 1, 0, "R9 zero ignored without branch");
        step(1, 0, 0, "R5 branch not taken");
        step(1, 1, 0, "R4 branch taken");
        step(0, 0, 1, "R6 jump");
        step(1, 1, 1, "R7 jump over branch");
        for (int k = 0; k < 300; k++) step(0, 0, 0, "R3 run past array end");
        // random mix
        for (int k = 0; k < 4000; k++) begin
            bit b, z, j;
            b = ($urandom % 3) == 0;
            z = $urandom % 2;
            j = ($urandom % 12) == 0;
            if (j && b && z)      step(b, z, j, "R7 jump priority");
            else if (j)           step(b, z, j, "R6 jump");
            else if (b && z)      step(b, z, j, "R4 branch taken");
            else if (b)           step(b, z, j, "R5 branch not taken");
            else if (z)           step(b, z, j, "R9 zero ignored");
            else                  step(b, z, j, "R3 sequential");
            check("R8 alignment", {30'd0, pc[1:0]}, 32'd0);
            if (k == 2000) do_reset();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule